// File: doc/BRIEF.md
# Video Filter Configuration Command Decoder

This block sits behind a two-wire serial slave byte engine and turns the bytes of a write transfer into configuration for a triple-channel analog video filter. The engine reports bus events as one-cycle strobes: a START or repeated START, a received write byte, a request for a read byte, and an abort (a STOP, a wrong address, or a transfer broken off early). The first write byte after a START is taken as an opcode. Most opcodes change a setting at once. One opcode arms the next byte of the same transfer as the new cutoff code. Three opcodes choose which register the next read returns.

The settings live in three registers. The mode register holds the clamp levels, filter bypass, sync polarity, sync source and power-down. The 8-bit cutoff register holds a linear code from 0 to 255. The input register holds the selected input set in bits 7:6. The outputs drive the analog path directly. Power-down only raises a flag. The decoder keeps working while it is set, and every stored setting survives it.

Top module: `vfilt_cmd_regs`

## Requirements
- R1: After reset the mode register reads 0x03, the cutoff code is 255, input set A is selected (in_sel = 0), bypass, power-down and external sync are off, and polarity is positive.
- R2: Opcodes 0x00/0x01 set the input 1 clamp low/high, 0x02/0x03 do the same for input 2, and 0x04/0x05 for input 3. clamp_hi[n-1] is high when input n clamps high.
- R3: Opcode 0x06 selects the internal sync source and 0x07 the external one. Opcode 0x0C selects positive external sync polarity and 0x0D negative.
- R4: Opcode 0x0E enables the filters (bypass = 0). Opcode 0x0F sets bypass = 1.
- R5: Opcodes 0x14, 0x15 and 0x16 select input set A, B and C (in_sel = 0, 1, 2). A read of the input register returns the selection in bits 7:6 with all other bits zero.
- R6: Opcode 0x12 arms a cutoff load. The next write byte of the same transfer becomes the cutoff code. Any further bytes in that transfer are ignored.
- R7: An abort, or a new START, that arrives before the armed data byte leaves the cutoff code unchanged. Write bytes that follow an abort are ignored until the next START.
- R8: Opcode 0x0A returns the mode register to 0x03. It leaves the cutoff code and the input selection unchanged.
- R9: Opcode 0x08 sets pwr_down and 0x09 clears it. Every other setting is kept, and opcodes received while powered down still take effect.
- R10: Opcodes 0x10, 0x11 and 0x13 select the mode, cutoff or input register for reading. The next read strobe returns that register once. rd_vld and rd_byte are valid in the cycle after rd_stb.
- R11: A read with no pending selection, including the read that follows a served one, returns the mode register.
- R12: The mode register layout is bit0 = input 2 clamp high, bit1 = input 3 clamp high, bit2 = input 1 clamp high, bit3 = bypass, bit4 = negative polarity, bit5 = external sync, bit6 = power-down, bit7 = 0.
- R13: Any opcode not listed (for example 0x0B, 0x17, 0x1F, 0xFF) changes nothing. Each START begins a fresh transfer whose first byte is again an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | START or repeated START seen |
| wr_stb | input | 1 | A write byte was received |
| wr_byte | input | 8 | Received write byte |
| rd_stb | input | 1 | Engine needs a read byte |
| abort | input | 1 | Transfer ended or discarded |
| rd_byte | output | 8 | Byte to transmit |
| rd_vld | output | 1 | rd_byte valid, one cycle after rd_stb |
| clamp_hi | output | 3 | Per-input high clamp level |
| bypass | output | 1 | Filters bypassed |
| sync_neg | output | 1 | Negative external sync polarity |
| sync_ext | output | 1 | External sync source |
| in_sel | output | 2 | Input set: 0 = A, 1 = B, 2 = C |
| pwr_down | output | 1 | Analog path powered down |
| cutoff | output | 8 | Filter cutoff code |

## Verification
The bench builds the block with the default cutoff reset value of 255. This puts the all-ones power-on code and the software-reset case, which must keep that code, within reach. Random transfers mix every listed opcode with unlisted ones and random data bytes, and they interleave aborts, repeated STARTs and reads. This exercises arming that is interrupted and read selections that stay pending across several transfers.

// File: rtl/vfilt_cmd_regs.sv
module vfilt_cmd_regs #(
  parameter logic [7:0] FREQ_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  input  logic       abort,
  output logic [7:0] rd_byte,
  output logic       rd_vld,
  output logic [2:0] clamp_hi,
  output logic       bypass,
  output logic       sync_neg,
  output logic       sync_ext,
  output logic [1:0] in_sel,
  output logic       pwr_down,
  output logic [7:0] cutoff
);
  localparam logic [7:0] MODE_INIT = 8'h03;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_FREQ} phase_t;

  phase_t     phase;
  logic [7:0] mode;
  logic [7:0] freq;
  logic [1:0] chan;
  logic [1:0] rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      mode    <= MODE_INIT;
      freq    <= FREQ_INIT;
      chan    <= 2'd0;
      rsel    <= 2'd0;
      rd_byte <= 8'h00;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= 1'b0;
      if (abort) phase <= PH_IDLE;
      else if (bus_start) phase <= PH_CMD;
      else if (wr_stb) begin
        case (phase)
          PH_CMD: begin
            phase <= PH_IDLE;
            case (wr_byte)
              8'h00: mode[2] <= 1'b0;
              8'h01: mode[2] <= 1'b1;
              8'h02: mode[0] <= 1'b0;
              8'h03: mode[0] <= 1'b1;
              8'h04: mode[1] <= 1'b0;
              8'h05: mode[1] <= 1'b1;
              8'h06: mode[5] <= 1'b0;
              8'h07: mode[5] <= 1'b1;
              8'h08: mode[6] <= 1'b1;
              8'h09: mode[6] <= 1'b0;
              8'h0A: mode    <= MODE_INIT;
              8'h0C: mode[4] <= 1'b0;
              8'h0D: mode[4] <= 1'b1;
              8'h0E: mode[3] <= 1'b0;
              8'h0F: mode[3] <= 1'b1;
              8'h10: rsel    <= 2'd0;
              8'h11: rsel    <= 2'd1;
              8'h12: phase   <= PH_FREQ;
              8'h13: rsel    <= 2'd2;
              8'h14: chan    <= 2'd0;
              8'h15: chan    <= 2'd1;
              8'h16: chan    <= 2'd2;
              default: ;
            endcase
          end
          PH_FREQ: begin
            freq  <= wr_byte;
            phase <= PH_IDLE;
          end
          default: ;
        endcase
      end
      if (rd_stb) begin
        rd_vld <= 1'b1;
        rsel   <= 2'd0;
        case (rsel)
          2'd1:    rd_byte <= freq;
          2'd2:    rd_byte <= {chan, 6'b0};
          default: rd_byte <= mode;
        endcase
      end
    end
  end

  assign clamp_hi = {mode[1], mode[0], mode[2]};
  assign bypass   = mode[3];
  assign sync_neg = mode[4];
  assign sync_ext = mode[5];
  assign pwr_down = mode[6];
  assign in_sel   = chan;
  assign cutoff   = freq;
endmodule

module vfilt_cmd_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       abort,
  input logic       rd_vld,
  input logic [2:0] clamp_hi,
  input logic       bypass,
  input logic       sync_neg,
  input logic       sync_ext,
  input logic       pwr_down,
  input logic [1:0] in_sel,
  input logic [7:0] cutoff
);
  // R6
  cutoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cutoff));
  // R7
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(cutoff));
  // R10
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld);
  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_vld);
  // R5
  in_sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel != 2'b11);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({clamp_hi, bypass, sync_neg, sync_ext, pwr_down, in_sel}));
endmodule

bind vfilt_cmd_regs vfilt_cmd_regs_chk i_vfilt_cmd_regs_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .abort(abort),
  .rd_vld(rd_vld), .clamp_hi(clamp_hi), .bypass(bypass), .sync_neg(sync_neg),
  .sync_ext(sync_ext), .pwr_down(pwr_down), .in_sel(in_sel), .cutoff(cutoff)
);

// File: tb/test_vfilt_cmd_regs.sv
module test_vfilt_cmd_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, abort = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_byte, cutoff;
  logic rd_vld, bypass, sync_neg, sync_ext, pwr_down;
  logic [2:0] clamp_hi;
  logic [1:0] in_sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_mode, m_freq;
  logic [1:0] m_chan;
  int m_ph, m_rs;

  always #2 clk = ~clk;

  vfilt_cmd_regs i_vfilt_cmd_regs (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .abort(abort), .rd_byte(rd_byte),
    .rd_vld(rd_vld), .clamp_hi(clamp_hi), .bypass(bypass), .sync_neg(sync_neg),
    .sync_ext(sync_ext), .in_sel(in_sel), .pwr_down(pwr_down), .cutoff(cutoff)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] port_mode();
    return {1'b0, pwr_down, sync_ext, sync_neg, bypass, clamp_hi[0], clamp_hi[2], clamp_hi[1]};
  endfunction

  task automatic chk_ports(string req);
    chk({req, " mode R12"}, port_mode(), m_mode);
    chk({req, " cutoff R6"}, cutoff, m_freq);
    chk({req, " in_sel R5"}, {6'b0, in_sel}, {6'b0, m_chan});
  endtask

  function automatic void m_write(logic [7:0] b);
    if (m_ph == 1) begin
      m_ph = 0;
      case (b)
        8'h00: m_mode[2] = 0; 8'h01: m_mode[2] = 1;
        8'h02: m_mode[0] = 0; 8'h03: m_mode[0] = 1;
        8'h04: m_mode[1] = 0; 8'h05: m_mode[1] = 1;
        8'h06: m_mode[5] = 0; 8'h07: m_mode[5] = 1;
        8'h08: m_mode[6] = 1; 8'h09: m_mode[6] = 0;
        8'h0A: m_mode = 8'h03;
        8'h0C: m_mode[4] = 0; 8'h0D: m_mode[4] = 1;
        8'h0E: m_mode[3] = 0; 8'h0F: m_mode[3] = 1;
        8'h10: m_rs = 0; 8'h11: m_rs = 1; 8'h13: m_rs = 2;
        8'h12: m_ph = 2;
        8'h14: m_chan = 0; 8'h15: m_chan = 1; 8'h16: m_chan = 2;
        default: ;
      endcase
    end else if (m_ph == 2) begin
      m_freq = b;
      m_ph = 0;
    end
  endfunction

  function automatic logic [7:0] m_read();
    logic [7:0] v;
    v = (m_rs == 1) ? m_freq : (m_rs == 2) ? {m_chan, 6'b0} : m_mode;
    m_rs = 0;
    return v;
  endfunction

  task automatic do_start();
    @(negedge clk) bus_start = 1;
    @(negedge clk) bus_start = 0;
    m_ph = 1;
  endtask

  task automatic do_abort();
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
    m_ph = 0;
  endtask

  task automatic do_wr(logic [7:0] b);
    @(negedge clk) begin wr_stb = 1; wr_byte = b; end
    @(negedge clk) wr_stb = 0;
    m_write(b);
  endtask

  task automatic do_rd(string req);
    logic [7:0] e;
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
    e = m_read();
    chk({req, " rd_vld"}, {7'b0, rd_vld}, 8'h01);
    chk({req, " rd_byte"}, rd_byte, e);
  endtask

  task automatic cmd(logic [7:0] op);
    do_start();
    do_wr(op);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [0:25];
    ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
            8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h13,
            8'h14, 8'h15, 8'h16, 8'h17, 8'h1F, 8'hFF};
    void'($urandom(32'h5EED_0017));
    m_mode = 8'h03; m_freq = 8'hFF; m_chan = 0; m_ph = 0; m_rs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", port_mode(), 8'h03);
    chk("R1 cutoff", cutoff, 8'hFF);
    chk("R1 in_sel", {6'b0, in_sel}, 8'h00);
    chk("R1 rd_vld", {7'b0, rd_vld}, 8'h00);
    // R13 bytes before any START ignored
    do_wr(8'h0F); chk_ports("R13 no start");
    // R2 clamps
    cmd(8'h01); cmd(8'h02); cmd(8'h04);
    chk("R2 clamp", {5'b0, clamp_hi}, 8'h01);
    // R3 sync
    cmd(8'h07); cmd(8'h0D);
    chk("R3 sync", {6'b0, sync_ext, sync_neg}, 8'h03);
    // R4 bypass
    cmd(8'h0F); chk("R4 bypass", {7'b0, bypass}, 8'h01);
    // R5 input select and read layout
    cmd(8'h16); chk("R5 in_sel C", {6'b0, in_sel}, 8'h02);
    cmd(8'h13); do_rd("R5 chan read");
    // R6 frequency load, extra bytes ignored
    cmd(8'h12); do_wr(8'h28); do_wr(8'h5A);
    chk("R6 cutoff", cutoff, 8'h28);
    // R7 abort before data
    cmd(8'h12); do_abort(); do_wr(8'h77);
    chk("R7 abort", cutoff, 8'h28);
    cmd(8'h12); do_start(); do_wr(8'h99);
    chk("R7 restart", cutoff, 8'h28);
    // R9 power-down keeps settings, commands still work
    cmd(8'h08); cmd(8'h15);
    chk_ports("R9 pd");
    cmd(8'h09); chk("R9 wake", {7'b0, pwr_down}, 8'h00);
    // R8 soft reset
    cmd(8'h0A);
    chk("R8 mode", port_mode(), 8'h03);
    chk("R8 cutoff", cutoff, 8'h28);
    chk("R8 in_sel", {6'b0, in_sel}, 8'h01);
    // R10 R11 reads
    cmd(8'h11); do_start(); do_rd("R10 freq read");
    do_rd("R11 after served");
    do_rd("R11 none pending");
    // R13 unknown opcodes
    cmd(8'h17); cmd(8'hFF); chk_ports("R13 unknown");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 3) do_start();
      else if (k < 7) begin
        if ($urandom_range(0, 3) == 0) do_wr(8'($urandom));
        else do_wr(ops[$urandom_range(0, 25)]);
      end else if (k < 8) do_abort();
      else do_rd("R10 random read");
      chk_ports("R13 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule